// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital input stage of a 12-bit serial-input digital-to-analog converter. Serial data enters a 12-bit input shift register, one bit for each qualified strobe edge, with the most significant bit first. A pair of active-low load inputs, both low together, copies the whole shift register into a 12-bit DAC register in parallel. Several instances can share one load line, so many converters can update at the same moment.

Four strobe inputs are provided. Three of them shift on a rising edge and one shifts on a falling edge. A strobe edge only counts while every other strobe rests at its idle level: low for the rising-edge strobes and high for the falling-edge strobe. Holding any strobe at its active level therefore blocks the others. An active-low asynchronous clear forces the DAC register to zero and leaves the shift register untouched.

All strobe, load and data inputs pass through a two-flop synchronizer into the system clock domain. Edges are found by comparing each synchronized strobe with its value one cycle earlier. The clear input bypasses the synchronizer.

Top module: `dacfe_top`

## Requirements
- R1: After a synchronous reset (rst_n low on a clock edge) both `shift_word` and `dac_word` read 0x000.
- R2: Twelve qualified strobe edges leave `shift_word` equal to the twelve sampled data bits, with the first bit in bit 11 (MSB first). Each edge shifts the register left by one and puts the new bit in bit 0.
- R3: Strobe lines 0, 1 and 3 (`stb_raw[0]`, `[1]`, `[3]`) shift one bit on a low-to-high transition and nothing on a high-to-low transition.
- R4: Strobe line 2 (`stb_raw[2]`) shifts one bit on a high-to-low transition and nothing on a low-to-high transition.
- R5: A strobe edge causes no shift while any other strobe sits at its active level (line 0, 1 or 3 high, or line 2 low).
- R6: The DAC register takes `shift_word` only on cycles where both bits of `ld_n` are low. With either bit high it holds its value.
- R7: While `clr_n` is low, `dac_word` is 0x000 at once and without a clock edge, even when a load is requested. Clear has priority over load.
- R8: Clear does not change `shift_word`, and strobes keep shifting while clear is low.
- R9: An input change applied before clock edge k shows at the outputs right after edge k+2 and not earlier.
- R10: When a load and a shift fall on the same cycle, the DAC register takes the shift register value from before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_din | input | 1 | Serial data bit |
| stb_raw | input | 4 | Strobe lines; lines 0, 1, 3 rise-active, line 2 fall-active |
| ld_n | input | 2 | Load lines, active low, both needed |
| clr_n | input | 1 | Asynchronous DAC register clear, active low |
| dac_word | output | 12 | DAC register contents |
| shift_word | output | 12 | Input shift register contents |

## Verification
A faulty edge qualifier shows up on `shift_word` two cycles after the strobe change that triggers it. It appears as a missing bit, an extra bit on the inactive edge, or a bit accepted while another strobe is held. Because the bench keeps a running model across every pulse, each such error is seen at the next check. A fault in the load or clear path shows on `dac_word`. A clear fault appears within the same time step. A load fault appears two edges after the load lines move, and the bench samples on each of those edges to pin the latency exactly.

// File: rtl/dacfe_pkg.sv
// Shared constants for the serial DAC input front end.
// Assumes a four-strobe arrangement where a set bit in the polarity mask
// marks a rise-active strobe and a clear bit marks a fall-active strobe.
package dacfe_pkg;
    localparam int WORD_W_DEF = 12;
    localparam int STB_N_DEF  = 4;
    localparam int LD_N_DEF   = 2;
    localparam logic [STB_N_DEF-1:0] STB_RISE_DEF = 4'b1011;
endpackage

// File: rtl/dacfe_sync.sv
// Two-stage synchronizer for a bundle of slow control inputs.
// Assumes every bit is quasi-static compared with clk, so per-bit skew of one
// cycle is acceptable. Reset loads RST_VAL into both stages.
module dacfe_sync #(
    parameter int          W       = 7,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    // Move the raw inputs through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            safe_q <= RST_VAL;
        end else begin
            meta_q <= d;
            safe_q <= meta_q;
        end
    end

    assign q = safe_q;
endmodule

// File: rtl/dacfe_strobe_qual.sv
// Finds qualified strobe edges. Each strobe has its own active edge, taken
// from RISE_MASK, and its edge only counts while every other strobe is at
// its idle level. Assumes inputs are already synchronized to clk.
module dacfe_strobe_qual #(
    parameter int                N         = 4,
    parameter logic [N-1:0]      RISE_MASK = 4'b1011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stb_cur,
    output logic         fire
);
    localparam logic [N-1:0] IDLE_LVL = ~RISE_MASK;

    logic [N-1:0] stb_prev;
    logic [N-1:0] hit;

    // Remember last cycle's strobe levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= IDLE_LVL;
        else        stb_prev <= stb_cur;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam logic [N-1:0] SELF = N'(1) << i;
        logic edge_seen;
        logic others_idle;
        if (RISE_MASK[i]) begin : g_rise
            assign edge_seen = ~stb_prev[i] & stb_cur[i];
        end else begin : g_fall
            assign edge_seen = stb_prev[i] & ~stb_cur[i];
        end
        assign others_idle = (((stb_cur ^ IDLE_LVL) & ~SELF) == '0);
        assign hit[i] = edge_seen & others_idle;
    end

    assign fire = |hit;
endmodule

// File: rtl/dacfe_shift.sv
// Serial-in, parallel-out input register. On each enabled cycle it shifts
// left and puts the new bit in bit 0, so the first bit ends up as the MSB.
// Assumes the data bit is aligned with the enable.
module dacfe_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sr_q;

    // Shift one bit per qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  sr_q <= '0;
        else if (en) sr_q <= {sr_q[W-2:0], din};
    end

    assign q = sr_q;
endmodule

// File: rtl/dacfe_hold.sv
// DAC holding register. Loads in parallel when load is high. An active-low
// asynchronous clear forces zero and wins over load. Assumes clr_n comes
// straight from a pin with no synchronizer.
module dacfe_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] hold_q;

    // Clear at once, reset on the clock edge, otherwise load on request.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      hold_q <= '0;
        else if (!rst_n) hold_q <= '0;
        else if (load)   hold_q <= d;
    end

    assign q = hold_q;
endmodule

// File: rtl/dacfe_top.sv
// Serial DAC input front end. Synchronizes data, strobes and load lines,
// qualifies strobe edges, shifts data MSB first into the input register and
// copies it into the DAC register when every load line is low. Assumes
// inputs change slowly compared with clk (several cycles per level).
module dacfe_top #(
    parameter int                         WORD_W   = dacfe_pkg::WORD_W_DEF,
    parameter int                         STB_N    = dacfe_pkg::STB_N_DEF,
    parameter int                         LD_N     = dacfe_pkg::LD_N_DEF,
    parameter logic [STB_N-1:0]           STB_RISE = dacfe_pkg::STB_RISE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_din,
    input  logic [STB_N-1:0]  stb_raw,
    input  logic [LD_N-1:0]   ld_n,
    input  logic              clr_n,
    output logic [WORD_W-1:0] dac_word,
    output logic [WORD_W-1:0] shift_word
);
    localparam int SYNC_W = 1 + LD_N + STB_N;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, {LD_N{1'b1}}, ~STB_RISE};

    logic [SYNC_W-1:0] sync_q;
    logic              din_s;
    logic [LD_N-1:0]   ld_s;
    logic [STB_N-1:0]  stb_s;
    logic              shift_en;
    logic              load_req;

    dacfe_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_din, ld_n, stb_raw}),
        .q     (sync_q)
    );

    assign {din_s, ld_s, stb_s} = sync_q;

    dacfe_strobe_qual #(.N(STB_N), .RISE_MASK(STB_RISE)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_cur (stb_s),
        .fire    (shift_en)
    );

    dacfe_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (shift_en),
        .din   (din_s),
        .q     (shift_word)
    );

    // Transfer only when every load line is low.
    assign load_req = (ld_s == '0);

    dacfe_hold #(.W(WORD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .load  (load_req),
        .d     (shift_word),
        .q     (dac_word)
    );
endmodule

// File: rtl/dacfe_chk.sv
// Port-level property checker for dacfe_top, attached by bind.
// Counts cycles since reset so that no $past reaches back before it.
module dacfe_chk #(
    parameter int WORD_W = 12,
    parameter int STB_N  = 4,
    parameter int LD_N   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic [STB_N-1:0]  stb_raw,
    input logic [LD_N-1:0]   ld_n,
    input logic [WORD_W-1:0] dac_word,
    input logic [WORD_W-1:0] shift_word
);
    logic [2:0] age;

    // Saturating count of clock edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)           age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd1) |-> (shift_word == '0 && dac_word == '0));

    a_r7_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_word == '0));

    a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && clr_n && $past(clr_n) && $past(ld_n, 3) != '0)
        |-> $stable(dac_word));

    a_r6_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && clr_n && $past(clr_n) && $past(ld_n, 3) == '0)
        |-> (dac_word == $past(shift_word)));

    a_r2_still_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && $past(stb_raw, 3) == $past(stb_raw, 4))
        |-> $stable(shift_word));
endmodule

bind dacfe_top dacfe_chk #(.WORD_W(WORD_W), .STB_N(STB_N), .LD_N(LD_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .stb_raw    (stb_raw),
    .ld_n       (ld_n),
    .dac_word   (dac_word),
    .shift_word (shift_word)
);

// File: tb/tb_dacfe_top.sv
`timescale 1ns/1ps
module tb_dacfe_top;
    localparam logic [3:0] IDLE = 4'b0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_din = 1'b0;
    logic [3:0]  stb_raw = IDLE;
    logic [1:0]  ld_n = 2'b11;
    logic        clr_n = 1'b1;
    logic [11:0] dac_word;
    logic [11:0] shift_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] model = '0;
    logic [11:0] exp_dac = '0;
    logic [11:0] old_v;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dacfe_top dut (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .stb_raw(stb_raw),
        .ld_n(ld_n), .clr_n(clr_n), .dac_word(dac_word), .shift_word(shift_word)
    );

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %03h expected %03h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    // One full strobe pulse on a line from idle; the active edge shifts, the return does not.
    task automatic pulse(input int idx, input logic b);
        string tag;
        tag = (idx == 2) ? "R4" : "R3";
        ser_din = b;
        step();
        stb_raw = stb_raw ^ (4'b1 << idx);
        step();
        model = {model[10:0], b};
        chk(tag, shift_word, model);
        stb_raw = stb_raw ^ (4'b1 << idx);
        step();
        chk(tag, shift_word, model);
    endtask

    initial begin
        @(negedge clk);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1", shift_word, 12'h000);
        chk("R1", dac_word, 12'h000);

        // R2/R3/R4: words through each strobe, MSB first, then load (R6).
        for (int idx = 0; idx < 4; idx++) begin
            for (int k = 0; k < 2; k++) begin
                logic [11:0] w;
                w = 12'(idx * 12'h359 + k * 12'hA6B + 12'h0F1);
                for (int b = 11; b >= 0; b--) pulse(idx, w[b]);
                chk("R2", shift_word, w);
                ld_n = 2'b00;
                step();
                exp_dac = w;
                chk("R6", dac_word, exp_dac);
                ld_n = 2'b11;
                step();
            end
        end

        // R5: every strobe blocked by every other strobe held active.
        for (int j = 0; j < 4; j++) begin
            for (int idx = 0; idx < 4; idx++) begin
                if (idx != j) begin
                    ser_din = ~model[0];
                    step();
                    stb_raw = IDLE ^ (4'b1 << j);
                    step();
                    model = {model[10:0], ser_din};
                    ser_din = ~ser_din;
                    step();
                    stb_raw = stb_raw ^ (4'b1 << idx);
                    step();
                    chk("R5", shift_word, model);
                    stb_raw = stb_raw ^ (4'b1 << idx);
                    step();
                    chk("R5", shift_word, model);
                    stb_raw = IDLE;
                    step();
                    chk("R5", shift_word, model);
                end
            end
        end

        // R7/R8: clear, with load requested, shift register untouched.
        ld_n = 2'b00;
        step();
        exp_dac = model;
        chk("R6", dac_word, exp_dac);
        ld_n = 2'b11;
        step();
        clr_n = 1'b0;
        #1;
        chk("R7", dac_word, 12'h000);
        @(negedge clk);
        ld_n = 2'b00;
        step();
        chk("R7", dac_word, 12'h000);
        chk("R8", shift_word, model);
        pulse(0, ~model[11]);
        chk("R8", shift_word, model);
        chk("R7", dac_word, 12'h000);
        clr_n = 1'b1;
        step();
        exp_dac = model;
        chk("R7", dac_word, exp_dac);
        ld_n = 2'b11;
        step();

        // R6: a single load line low does nothing.
        pulse(3, ~model[0]);
        ld_n = 2'b10;
        step();
        chk("R6", dac_word, exp_dac);
        ld_n = 2'b01;
        step();
        chk("R6", dac_word, exp_dac);
        ld_n = 2'b11;
        step();

        // R9: load latency is two edges after the first sampling edge.
        ld_n = 2'b00;
        @(negedge clk);
        chk("R9", dac_word, exp_dac);
        @(negedge clk);
        chk("R9", dac_word, exp_dac);
        @(negedge clk);
        exp_dac = model;
        chk("R9", dac_word, exp_dac);
        ld_n = 2'b11;
        step();

        // R10: one-cycle load on the same cycle as a shift takes the old value.
        ser_din = ~model[0];
        step();
        old_v = model;
        ld_n = 2'b00;
        stb_raw = IDLE ^ 4'b0001;
        @(negedge clk);
        ld_n = 2'b11;
        step();
        model = {model[10:0], ser_din};
        chk("R10", dac_word, old_v);
        chk("R10", shift_word, model);
        stb_raw = IDLE;
        step();
        chk("R10", dac_word, old_v);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule